// File: doc/BRIEF.md
# Word-Wide CRC-32 Generator and Checker

This block computes the 32-bit cyclic redundancy check used on network frames. It takes a full 32-bit data word on every clock instead of one bit per clock, so it keeps pace with multi-gigabit links. Each frame is marked with a start flag on its first word and an end flag on its last word. The last word may carry only one, two or three valid bytes.

The same engine serves both directions. In generate mode, the complemented result after the last word is the frame check sequence that the transmitter appends. In check mode, the receiver runs the engine over the frame together with its received check sequence, and the block reports whether the well-known constant residue was reached. A build-time switch can add one register stage in front of the update network, which shortens the critical path at the cost of one cycle of latency.

Top module: `crc32_par_engine`

## Requirements
- R1: The CRC uses the reflected generator 0xEDB88320, which is the bit-reversed form of 0x04C11DB7. The register is preset to all ones, and `crc_out` always shows the bitwise complement of the register. The nine ASCII bytes "123456789" give 0xCBF43926.
- R2: Byte lane order: bits [7:0] of `in_data` hold the earliest byte of the word, then [15:8], [23:16] and [31:24]. Each byte enters the CRC least-significant bit first.
- R3: A valid word with `in_sof` high is folded into the all-ones preset rather than into the previous state. A single-word frame may carry `in_sof` and `in_eof` together.
- R4: On a valid word with `in_eof` high, `in_last_cnt` gives the number of valid bytes in that word: 1, 2 or 3 as written, and 0 meaning all four. Only the lowest lanes are used. On words without `in_eof`, `in_last_cnt` has no effect and all four bytes are used.
- R5: A cycle with `in_valid` low leaves the CRC state and `crc_out` unchanged, whatever the other inputs carry.
- R6: `crc_done` is high for exactly one cycle, 1 + PIPE_EN cycles after the clock edge that accepts a valid `in_eof` word. `crc_out` holds the final value in that cycle.
- R7: `crc_ok` is high together with `crc_done` only when the frame's last word carried `in_check` high and the register holds the residue 0xDEBB20E3. In that case `crc_out` reads 0x2144DF1C. Otherwise `crc_ok` stays low.
- R8: After reset, `crc_out` is 0 and `crc_done` and `crc_ok` are low.
- R9: The first word of a new frame may follow the last word of the previous frame in the very next cycle. Both frames produce correct results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Word qualifier |
| in_sof | input | 1 | First word of a frame |
| in_eof | input | 1 | Last word of a frame |
| in_last_cnt | input | 2 | Valid bytes in the last word (0 means 4) |
| in_check | input | 1 | Check mode for the frame (sampled with the last word) |
| in_data | input | 32 | Data word, lane 0 in bits [7:0] |
| crc_out | output | 32 | Complemented running CRC |
| crc_done | output | 1 | One-cycle pulse after the frame's last word |
| crc_ok | output | 1 | Residue match in check mode, with `crc_done` |

## Verification
Two pairs of functions can coincide. The start preset and the ragged-end byte selection meet when a frame of one to four bytes carries start and end flags in the same word. The done pulse of one frame meets the first update of the next frame when frames run back to back with no idle cycle. The bench builds both cases: a three-byte single-word frame, and two frames of different lengths sent with no gap. Each captured result is compared against a bit-serial reference model in the bench, and the bench confirms that exactly one done pulse appears per frame.

// File: rtl/crc32_pkg.sv
package crc32_pkg;

  localparam int CRC_W     = 32;
  localparam int CRC_LANES = 4;
  localparam int DATA_W    = 8 * CRC_LANES;
  localparam int CNT_W     = $clog2(CRC_LANES);

  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_PRESET    = 32'hFFFFFFFF;
  localparam logic [CRC_W-1:0] CRC_RESIDUE   = 32'hDEBB20E3;
  localparam logic [CRC_W-1:0] CRC_OK_OUT    = ~CRC_RESIDUE;

  typedef struct packed {
    logic              sof;
    logic              eof;
    logic              chk;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] data;
  } crc_beat_t;

  // Folds the lowest nlanes bytes of a word into the state, lane 0 first,
  // each byte least-significant bit first. Unrolls into an XOR network.
  function automatic logic [CRC_W-1:0] crc_fold_lanes(
    input logic [CRC_W-1:0]  st,
    input logic [DATA_W-1:0] d,
    input int                nlanes
  );
    logic [CRC_W-1:0] c;
    c = st;
    for (int b = 0; b < CRC_LANES; b++) begin
      if (b < nlanes) begin
        c = c ^ {{(CRC_W-8){1'b0}}, d[8*b +: 8]};
        for (int i = 0; i < 8; i++) begin
          c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
        end
      end
    end
    return c;
  endfunction

endpackage

// File: rtl/crc32_rst_sync.sv
module crc32_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/crc32_word_net.sv
module crc32_word_net
  import crc32_pkg::*;
(
  input  logic [CRC_W-1:0]  state_i,
  input  logic              sof_i,
  input  logic              eof_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  next_o
);

  logic [CRC_W-1:0] seed;
  logic [CRC_W-1:0] net_res [CRC_LANES];
  logic [CNT_W-1:0] sel;

  // Start of frame folds the word into the preset, not the old state.
  assign seed = sof_i ? CRC_PRESET : state_i;

  // One dedicated network per possible byte count of a word.
  for (genvar g = 0; g < CRC_LANES; g++) begin : g_net
    assign net_res[g] = crc_fold_lanes(seed, data_i, g + 1);
  end

  always_comb begin
    if (!eof_i || (cnt_i == '0)) sel = CNT_W'(CRC_LANES - 1);
    else                         sel = cnt_i - CNT_W'(1);
  end

  assign next_o = net_res[sel];

endmodule

// File: rtl/crc32_state.sv
module crc32_state
  import crc32_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_v,
  input  crc_beat_t        upd,
  input  logic [CRC_W-1:0] next_i,
  output logic [CRC_W-1:0] state_o,
  output logic [CRC_W-1:0] crc_o,
  output logic             done_o,
  output logic             ok_o
);

  logic [CRC_W-1:0] state_q, state_d;
  logic             done_q, done_d;
  logic             ok_q, ok_d;

  always_comb begin
    state_d = state_q;
    if (upd_v) state_d = next_i;
    done_d = upd_v && upd.eof;
    ok_d   = upd_v && upd.eof && upd.chk && (next_i == CRC_RESIDUE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CRC_PRESET;
      done_q  <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      ok_q    <= ok_d;
    end
  end

  assign state_o = state_q;
  assign crc_o   = ~state_q;
  assign done_o  = done_q;
  assign ok_o    = ok_q;

  // R6
  done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_v && upd.eof) |=> done_o);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o || $past(upd_v && upd.eof));

  // R7
  ok_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok_o |-> done_o);

  // R7
  residue_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok_o |-> (crc_o == CRC_OK_OUT));

endmodule

// File: rtl/crc32_par_engine.sv
module crc32_par_engine
  import crc32_pkg::*;
#(
  parameter bit PIPE_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [CNT_W-1:0]  in_last_cnt,
  input  logic              in_check,
  input  logic [DATA_W-1:0] in_data,
  output logic [CRC_W-1:0]  crc_out,
  output logic              crc_done,
  output logic              crc_ok
);

  logic             rst_s_n;
  crc_beat_t        beat_in;
  crc_beat_t        upd;
  logic             upd_v;
  logic [CRC_W-1:0] state_cur;
  logic [CRC_W-1:0] state_nxt;

  crc32_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  assign beat_in = '{sof: in_sof, eof: in_eof, chk: in_check,
                     cnt: in_last_cnt, data: in_data};

  if (PIPE_EN) begin : g_pipe
    logic      v_q;
    crc_beat_t beat_q;

    always_ff @(posedge clk or negedge rst_s_n) begin
      if (!rst_s_n) v_q <= 1'b0;
      else          v_q <= in_valid;
    end

    // Payload register: clock-enabled, no reset needed.
    always_ff @(posedge clk) begin
      if (in_valid) beat_q <= beat_in;
    end

    assign upd_v = v_q;
    assign upd   = beat_q;

    // R6
    stage_fwd_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
      in_valid |=> upd_v);
  end else begin : g_flow
    assign upd_v = in_valid;
    assign upd   = beat_in;
  end

  crc32_word_net u_net (
    .state_i (state_cur),
    .sof_i   (upd.sof),
    .eof_i   (upd.eof),
    .cnt_i   (upd.cnt),
    .data_i  (upd.data),
    .next_o  (state_nxt)
  );

  crc32_state u_state (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .upd_v   (upd_v),
    .upd     (upd),
    .next_i  (state_nxt),
    .state_o (state_cur),
    .crc_o   (crc_out),
    .done_o  (crc_done),
    .ok_o    (crc_ok)
  );

  // R5
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!in_valid && !upd_v) |=> $stable(crc_out));

endmodule

// File: tb/crc32_par_engine_tb.sv
module crc32_par_engine_tb;

  localparam bit PIPE = 1'b1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_sof = 1'b0;
  logic        in_eof = 1'b0;
  logic [1:0]  in_last_cnt = 2'd0;
  logic        in_check = 1'b0;
  logic [31:0] in_data = 32'h0;
  logic [31:0] crc_out;
  logic        crc_done;
  logic        crc_ok;

  int n_chk = 0;
  int n_fail = 0;
  bit ended = 1'b0;

  logic [7:0]  fb [0:63];
  int          fb_n;
  logic [31:0] cap_crc [0:15];
  logic        cap_ok  [0:15];
  int          cap_n = 0;

  always #5 clk = ~clk;

  crc32_par_engine #(.PIPE_EN(PIPE)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_last_cnt(in_last_cnt), .in_check(in_check),
    .in_data(in_data), .crc_out(crc_out), .crc_done(crc_done), .crc_ok(crc_ok)
  );

  always @(negedge clk) begin
    if (crc_done && cap_n < 16) begin
      cap_crc[cap_n] = crc_out;
      cap_ok[cap_n]  = crc_ok;
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input bit cond, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int from, input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int k = from; k < from + n; k++) begin
      for (int i = 0; i < 8; i++) begin
        logic fbk = c[0] ^ fb[k][i];
        c = c >> 1;
        if (fbk) c = c ^ 32'hEDB88320;
      end
    end
    return ~c;
  endfunction

  task automatic fill(input int n, input logic [7:0] seed);
    for (int k = 0; k < n; k++) fb[k] = seed + 8'(k * 37) ^ 8'(k >> 2);
    fb_n = n;
  endtask

  // Sends fb[from +: n] as one frame. gap_w: insert idle cycles after that word.
  task automatic send_frame(input int from, input int n, input bit check,
                            input int gap_w, input bit idle_after);
    int nw = (n + 3) / 4;
    for (int w = 0; w < nw; w++) begin
      logic [31:0] d;
      for (int b = 0; b < 4; b++) begin
        int idx = w * 4 + b;
        d[8*b +: 8] = (idx < n) ? fb[from + idx] : 8'hA5;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_sof = (w == 0);
      in_eof = (w == nw - 1);
      in_check = check;
      in_data = d;
      // R4: field set to 1 on non-final words, must have no effect
      in_last_cnt = (w == nw - 1) ? 2'(n % 4) : 2'd1;
      if (w == gap_w) begin
        logic [31:0] s1;
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b1; in_eof = 1'b1; in_data = 32'hDEADBEEF;
        @(negedge clk);
        @(negedge clk);
        s1 = crc_out;
        in_data = 32'h12345678;
        @(negedge clk);
        chk(crc_out == s1, "R5 idle holds crc_out", crc_out, s1);
        in_sof = 1'b0; in_eof = 1'b0;
      end
    end
    if (idle_after) begin
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    end
  endtask

  task automatic wait_caps(input int want);
    for (int i = 0; i < 10 && cap_n < want; i++) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(crc_out == 32'h0, "R8 reset crc_out", crc_out, 32'h0);
    chk(crc_done == 1'b0, "R8 reset done", {31'h0, crc_done}, 32'h0);
    chk(crc_ok == 1'b0, "R8 reset ok", {31'h0, crc_ok}, 32'h0);
  endtask

  task automatic t_vector;
    string s = "123456789";
    for (int k = 0; k < 9; k++) fb[k] = s[k];
    cap_n = 0;
    send_frame(0, 9, 1'b0, -1, 1'b1);
    wait_caps(1);
    chk(cap_n == 1, "R1 one done per frame", cap_n, 1);
    chk(cap_crc[0] == 32'hCBF43926, "R1 R2 known vector", cap_crc[0], 32'hCBF43926);
    chk(cap_ok[0] == 1'b0, "R7 generate mode no ok", {31'h0, cap_ok[0]}, 32'h0);
  endtask

  task automatic t_lengths;
    for (int n = 5; n <= 8; n++) begin
      logic [31:0] e;
      fill(n, 8'(n * 11));
      e = ref_crc(0, n);
      cap_n = 0;
      send_frame(0, n, 1'b0, -1, 1'b1);
      wait_caps(1);
      chk(cap_n == 1 && cap_crc[0] == e, "R4 ragged last word", cap_crc[0], e);
    end
  endtask

  task automatic t_gap;
    logic [31:0] e;
    fill(14, 8'h3C);
    e = ref_crc(0, 14);
    cap_n = 0;
    send_frame(0, 14, 1'b0, 1, 1'b1);
    wait_caps(1);
    chk(cap_n == 1 && cap_crc[0] == e, "R5 gap in frame", cap_crc[0], e);
  endtask

  task automatic t_check;
    logic [31:0] f;
    fill(10, 8'h77);
    f = ref_crc(0, 10);
    for (int b = 0; b < 4; b++) fb[10 + b] = f[8*b +: 8];
    cap_n = 0;
    send_frame(0, 14, 1'b1, -1, 1'b1);
    wait_caps(1);
    chk(cap_n == 1 && cap_ok[0] == 1'b1, "R7 good frame passes", {31'h0, cap_ok[0]}, 32'h1);
    chk(cap_crc[0] == 32'h2144DF1C, "R7 residue value", cap_crc[0], 32'h2144DF1C);
    cap_n = 0;
    send_frame(0, 14, 1'b0, -1, 1'b1);
    wait_caps(1);
    chk(cap_n == 1 && cap_ok[0] == 1'b0, "R7 generate mode never ok", {31'h0, cap_ok[0]}, 32'h0);
    fb[3] = fb[3] ^ 8'h10;
    cap_n = 0;
    send_frame(0, 14, 1'b1, -1, 1'b1);
    wait_caps(1);
    chk(cap_n == 1 && cap_ok[0] == 1'b0, "R7 corrupt frame fails", {31'h0, cap_ok[0]}, 32'h0);
  endtask

  task automatic t_single;
    logic [31:0] e;
    fill(3, 8'hC1);
    e = ref_crc(0, 3);
    cap_n = 0;
    send_frame(0, 3, 1'b0, -1, 1'b1);
    wait_caps(1);
    chk(cap_n == 1 && cap_crc[0] == e, "R3 sof and eof same word", cap_crc[0], e);
  endtask

  task automatic t_b2b;
    logic [31:0] ea, eb;
    fill(20, 8'h19);
    ea = ref_crc(0, 7);
    eb = ref_crc(7, 13);
    cap_n = 0;
    send_frame(0, 7, 1'b0, -1, 1'b0);
    send_frame(7, 13, 1'b0, -1, 1'b1);
    wait_caps(2);
    chk(cap_n == 2, "R9 two done pulses", cap_n, 2);
    chk(cap_crc[0] == ea, "R9 first frame", cap_crc[0], ea);
    chk(cap_crc[1] == eb, "R3 R9 second frame preset", cap_crc[1], eb);
  endtask

  task automatic t_latency;
    int lat = 0;
    int width = 0;
    @(negedge clk);
    in_valid = 1'b1; in_sof = 1'b1; in_eof = 1'b1; in_last_cnt = 2'd0;
    in_check = 1'b0; in_data = 32'h0BADF00D;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (crc_done) begin
        width++;
        if (lat == 0) lat = k;
      end
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    end
    chk(lat == 1 + int'(PIPE), "R6 done latency", lat, 1 + int'(PIPE));
    chk(width == 1, "R6 done one cycle", width, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_vector();
    t_lengths();
    t_gap();
    t_check();
    t_single();
    t_b2b();
    t_latency();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule